// File: doc/BRIEF.md
# Real-Time Clock Interrupt Status and Control

This block collects the timing events of a real-time clock and turns them into status flags and two active-low interrupt pins. Six periodic rate ticks, an alarm-match pulse, two spare event pulses and a power-fail level come in as inputs. Each event leaves a flag in a main status register. The rate ticks also leave flags in a separate periodic flag register. A set of enable bits decides which flags reach the pins. Power-fail indication can be steered to a second, multifunction pin instead of the main interrupt pin.

A processor reaches the block through a small paged register port with an address, a read strobe, a write strobe and data. A page bit and a bank bit sit in the main status register. Bank 0 holds the flags and the output routing. Bank 1 holds the enables. Each flag has its own clearing rule:

- alarm, periodic-summary and spare flags clear when a one is written to their bit;
- the periodic flag register clears whenever it is read;
- the power-fail flag clears only when the power-fail input drops.

Bit 0 of the main status register reflects the pin state, so one read of a wired interrupt line tells software whether this device is a source.

Top module: `rtc_irq_ctrl`

## Requirements
- R1: After reset every flag, enable, routing bit, page bit and bank bit is 0. Reads of addresses 0, 2 and 3 return 0x00, and `intr_n` and `mfo_n` are both 1.
- R2: Periodic flag register (address 3, page 0, bank 0). Bit i sets on any cycle with `tick[i]` high, whatever the enables are. A read of it returns the flags in the read cycle and clears them all. A tick that arrives in the same cycle as the read leaves its bit set.
- R3: Main status bit 3 sets only on a cycle where some `tick[i]` is high and rate enable i (bit i of enable register A, address 3 in bank 1) is 1. While it is set and any rate enable is 1, `intr_n` is 0.
- R4: An `evt_alarm` pulse sets main status bit 2 whatever the enables are. `intr_n` is driven low by it only while alarm enable (bit 1 of enable register B, address 4 in bank 1) is 1.
- R5: Main status bits 2 through 5 clear on a write to address 0 with a 1 in that bit position. A 0 there leaves the bit unchanged. An event in the same cycle as the clearing write keeps the bit set.
- R6: Main status bit 1 sets only while `pwr_fail` is 1 and power-fail enable (bit 0 of enable register B) is 1. It stays set until `pwr_fail` returns to 0, and writing a 1 to it does not clear it.
- R7: With routing bit 0 of the output mode register (address 2, bank 0) at 1, a power-fail condition drives `mfo_n` low and leaves `intr_n` high. With the routing bit at 0 it drives `intr_n` low instead.
- R8: Bit 0 of the main status register reads 1 exactly when `intr_n` or `mfo_n` is low.
- R9: With every enable bit at 0, no event drives `intr_n` or `mfo_n` low, and the flags set as described can still be read.
- R10: Address 0 always reads the main status register. Bit 7 is the page select and bit 6 is the bank select, and both are written directly. When page select is 1, every other address reads 0x00, ignores writes and has no read side effect.
- R11: An `evt_aux[k]` pulse sets main status bit 4+k. It drives `intr_n` low only while bit 2+k of enable register B is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 3 | Register address |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of the strobe |
| tick | input | 6 | Periodic rate pulses (1 ms, 10 ms, 100 ms, 1 s, 10 s, 60 s) |
| evt_alarm | input | 1 | Alarm match pulse |
| evt_aux | input | 2 | Spare event pulses |
| pwr_fail | input | 1 | Power-fail level, 1 while supply is bad |
| intr_n | output | 1 | Interrupt output, active low |
| mfo_n | output | 1 | Multifunction output, active low |

## Verification
The hardest case to reach is an event pulse that lands in the very cycle that clears its flag. This covers a tick during a periodic-flag read and an alarm pulse during a write-one clear. The bench has dedicated tasks that raise the strobe and the event together on one falling edge, so both reach the same rising edge. The flag is then read back in a later access. Paging side effects are also hard to see: a page-1 read of address 3 must not clear the periodic flags. The bench proves this by switching back to page 0 and finding the flags still there.

// File: rtl/rtc_irq_pkg.sv
// Package: shared constants for the RTC interrupt block.
// Holds register addresses, bit positions and widths used by the modules
// and the checker. Assumes an 8-bit data bus.
package rtc_irq_pkg;
    localparam int DATA_W    = 8;
    localparam int ADDR_W    = 3;
    localparam int NUM_RATES = 6;
    localparam int NUM_AUX   = 2;
    localparam int ENB_W     = 2 + NUM_AUX;

    localparam logic [ADDR_W-1:0] A_MAIN  = 3'd0;
    localparam logic [ADDR_W-1:0] A_OMODE = 3'd2;
    localparam logic [ADDR_W-1:0] A_PFLAG = 3'd3;   // bank 0
    localparam logic [ADDR_W-1:0] A_ENA   = 3'd3;   // bank 1
    localparam logic [ADDR_W-1:0] A_ENB   = 3'd4;   // bank 1

    localparam int B_SUM   = 0;
    localparam int B_PF    = 1;
    localparam int B_ALARM = 2;
    localparam int B_PER   = 3;
    localparam int B_AUX0  = 4;
    localparam int B_BANK  = 6;
    localparam int B_PAGE  = 7;
endpackage

// File: rtl/rtc_irq_periodic.sv
// Periodic flag register and periodic-summary event.
// Each rate flag sets on its tick and clears as a whole on a read strobe.
// Assumes ticks are single-cycle pulses. A tick wins over a clear.
module rtc_irq_periodic #(
    parameter int NUM_RATES = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_RATES-1:0] tick,
    input  logic [NUM_RATES-1:0] rate_en,
    input  logic                 rd_clear,
    output logic [NUM_RATES-1:0] pflag_q,
    output logic                 per_evt
);
    // Hold rate flags; clear on read, new ticks take priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pflag_q <= '0;
        end else begin
            pflag_q <= (rd_clear ? '0 : pflag_q) | tick;
        end
    end

    // Enabled ticks form the event for main status bit 3.
    always_comb begin
        per_evt = |(tick & rate_en);
    end
endmodule

// File: rtl/rtc_irq_status.sv
// Main status flags D1..D5.
// D2..D5 set on their events and clear on a write-one strobe, with the event
// winning. D1 (power fail) sets while enabled during a fail and follows the
// fail level back down.
module rtc_irq_status #(
    parameter int NUM_AUX = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               per_evt,
    input  logic               evt_alarm,
    input  logic [NUM_AUX-1:0] evt_aux,
    input  logic               pwr_fail,
    input  logic               pf_en,
    input  logic               clr_alarm,
    input  logic               clr_per,
    input  logic [NUM_AUX-1:0] clr_aux,
    output logic               pf_q,
    output logic               alarm_q,
    output logic               per_q,
    output logic [NUM_AUX-1:0] aux_q
);
    // Power-fail flag: armed by enable, held until the input drops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pf_q <= 1'b0;
        end else begin
            pf_q <= pwr_fail & (pf_q | pf_en);
        end
    end

    // Alarm and periodic-summary flags with write-one clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alarm_q <= 1'b0;
            per_q   <= 1'b0;
        end else begin
            alarm_q <= (alarm_q & ~clr_alarm) | evt_alarm;
            per_q   <= (per_q & ~clr_per) | per_evt;
        end
    end

    // Spare event flags, one per input, same clearing rule.
    for (genvar k = 0; k < NUM_AUX; k++) begin : g_aux
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                aux_q[k] <= 1'b0;
            end else begin
                aux_q[k] <= (aux_q[k] & ~clr_aux[k]) | evt_aux[k];
            end
        end
    end
endmodule

// File: rtl/rtc_irq_outputs.sv
// Output gating: combines flags with enables, routes power fail to one pin,
// and forms the summary bit from the pin states.
// Assumes all inputs come from registers, so the pins do not glitch.
module rtc_irq_outputs #(
    parameter int NUM_RATES = 6,
    parameter int NUM_AUX   = 2
) (
    input  logic                 pf_q,
    input  logic                 alarm_q,
    input  logic                 per_q,
    input  logic [NUM_AUX-1:0]   aux_q,
    input  logic                 pf_en,
    input  logic                 alarm_en,
    input  logic [NUM_AUX-1:0]   aux_en,
    input  logic [NUM_RATES-1:0] rate_en,
    input  logic                 pf_to_mfo,
    output logic                 intr_n,
    output logic                 mfo_n,
    output logic                 summary
);
    logic pf_act;
    logic intr_req;
    logic mfo_req;

    // Gate each flag by its enable and pick the pin for power fail.
    always_comb begin
        pf_act   = pf_q & pf_en;
        intr_req = (alarm_q & alarm_en) | (per_q & (|rate_en))
                 | (|(aux_q & aux_en)) | (pf_act & ~pf_to_mfo);
        mfo_req  = pf_act & pf_to_mfo;
        intr_n   = ~intr_req;
        mfo_n    = ~mfo_req;
        summary  = intr_req | mfo_req;
    end
endmodule

// File: rtl/rtc_irq_ctrl.sv
// Top of the RTC interrupt block: register port decode, enable and routing
// registers, and the flag and output submodules.
// Assumes single-cycle read/write strobes that are never both high. Read data
// is combinational and shows pre-clear values in the strobe cycle.
module rtc_irq_ctrl
    import rtc_irq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_rd,
    input  logic                 bus_wr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic [NUM_RATES-1:0] tick,
    input  logic                 evt_alarm,
    input  logic [NUM_AUX-1:0]   evt_aux,
    input  logic                 pwr_fail,
    output logic                 intr_n,
    output logic                 mfo_n
);
    logic                 page_q;
    logic                 bank_q;
    logic                 pf_to_mfo;
    logic [NUM_RATES-1:0] rate_en;
    logic [ENB_W-1:0]     enb_q;
    logic                 hit_main_wr;
    logic                 hit_omode_wr;
    logic                 hit_ena_wr;
    logic                 hit_enb_wr;
    logic                 pflag_rd;
    logic [NUM_RATES-1:0] pflag_q;
    logic                 per_evt;
    logic                 pf_q;
    logic                 alarm_q;
    logic                 per_q;
    logic [NUM_AUX-1:0]   aux_q;
    logic [NUM_AUX-1:0]   clr_aux;
    logic                 summary;
    logic                 pg0_b0;
    logic                 pg0_b1;

    // Decode page/bank windows and the access strobes.
    always_comb begin
        pg0_b0       = ~page_q & ~bank_q;
        pg0_b1       = ~page_q &  bank_q;
        hit_main_wr  = bus_wr & (bus_addr == A_MAIN);
        hit_omode_wr = bus_wr & pg0_b0 & (bus_addr == A_OMODE);
        hit_ena_wr   = bus_wr & pg0_b1 & (bus_addr == A_ENA);
        hit_enb_wr   = bus_wr & pg0_b1 & (bus_addr == A_ENB);
        pflag_rd     = bus_rd & pg0_b0 & (bus_addr == A_PFLAG);
        clr_aux      = hit_main_wr ? bus_wdata[B_AUX0 +: NUM_AUX] : '0;
    end

    // Page/bank select bits, written through the main status address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_q <= 1'b0;
            bank_q <= 1'b0;
        end else if (hit_main_wr) begin
            page_q <= bus_wdata[B_PAGE];
            bank_q <= bus_wdata[B_BANK];
        end
    end

    // Enable registers A (rates) and B (power fail, alarm, spares).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rate_en <= '0;
            enb_q   <= '0;
        end else begin
            if (hit_ena_wr) rate_en <= bus_wdata[NUM_RATES-1:0];
            if (hit_enb_wr) enb_q   <= bus_wdata[ENB_W-1:0];
        end
    end

    // Output mode register: bit 0 steers power fail to the multifunction pin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pf_to_mfo <= 1'b0;
        end else if (hit_omode_wr) begin
            pf_to_mfo <= bus_wdata[0];
        end
    end

    rtc_irq_periodic #(.NUM_RATES(NUM_RATES)) u_periodic (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .rate_en  (rate_en),
        .rd_clear (pflag_rd),
        .pflag_q  (pflag_q),
        .per_evt  (per_evt)
    );

    rtc_irq_status #(.NUM_AUX(NUM_AUX)) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .per_evt   (per_evt),
        .evt_alarm (evt_alarm),
        .evt_aux   (evt_aux),
        .pwr_fail  (pwr_fail),
        .pf_en     (enb_q[0]),
        .clr_alarm (hit_main_wr & bus_wdata[B_ALARM]),
        .clr_per   (hit_main_wr & bus_wdata[B_PER]),
        .clr_aux   (clr_aux),
        .pf_q      (pf_q),
        .alarm_q   (alarm_q),
        .per_q     (per_q),
        .aux_q     (aux_q)
    );

    rtc_irq_outputs #(.NUM_RATES(NUM_RATES), .NUM_AUX(NUM_AUX)) u_outputs (
        .pf_q      (pf_q),
        .alarm_q   (alarm_q),
        .per_q     (per_q),
        .aux_q     (aux_q),
        .pf_en     (enb_q[0]),
        .alarm_en  (enb_q[1]),
        .aux_en    (enb_q[2 +: NUM_AUX]),
        .rate_en   (rate_en),
        .pf_to_mfo (pf_to_mfo),
        .intr_n    (intr_n),
        .mfo_n     (mfo_n),
        .summary   (summary)
    );

    // Read multiplexer over the visible registers of the current window.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_MAIN) begin
            bus_rdata[B_SUM]                = summary;
            bus_rdata[B_PF]                 = pf_q;
            bus_rdata[B_ALARM]              = alarm_q;
            bus_rdata[B_PER]                = per_q;
            bus_rdata[B_AUX0 +: NUM_AUX]    = aux_q;
            bus_rdata[B_BANK]               = bank_q;
            bus_rdata[B_PAGE]               = page_q;
        end else if (pg0_b0 && bus_addr == A_OMODE) begin
            bus_rdata[0] = pf_to_mfo;
        end else if (pg0_b0 && bus_addr == A_PFLAG) begin
            bus_rdata[NUM_RATES-1:0] = pflag_q;
        end else if (pg0_b1 && bus_addr == A_ENA) begin
            bus_rdata[NUM_RATES-1:0] = rate_en;
        end else if (pg0_b1 && bus_addr == A_ENB) begin
            bus_rdata[ENB_W-1:0] = enb_q;
        end
    end
endmodule

// File: rtl/rtc_irq_ctrl_chk.sv
// Checker for rtc_irq_ctrl: temporal properties on ports and internal state.
// Attached to every instance of the top by the bind at the end of this file.
module rtc_irq_ctrl_chk
    import rtc_irq_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic                 bus_rd,
    input logic                 bus_wr,
    input logic [DATA_W-1:0]    bus_wdata,
    input logic [DATA_W-1:0]    bus_rdata,
    input logic [NUM_RATES-1:0] tick,
    input logic                 evt_alarm,
    input logic                 pwr_fail,
    input logic                 intr_n,
    input logic                 mfo_n,
    input logic                 pflag_rd,
    input logic [NUM_RATES-1:0] pflag_q,
    input logic                 pf_q,
    input logic                 alarm_q,
    input logic [NUM_RATES-1:0] rate_en,
    input logic [ENB_W-1:0]     enb_q,
    input logic                 pf_to_mfo
);
    // R2: a read with no tick leaves the flags empty
    p_pflag_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pflag_rd && tick == '0) |=> (pflag_q == '0));

    // R2: a tick always shows in the flags one cycle later
    p_tick_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick != '0) |=> ((pflag_q & $past(tick)) == $past(tick)));

    // R4: an alarm pulse always sets the alarm flag
    p_alarm_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        evt_alarm |=> alarm_q);

    // R5: writing 0 to the alarm bit keeps a set flag
    p_wr0_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_q && bus_wr && bus_addr == A_MAIN && !bus_wdata[B_ALARM]) |=> alarm_q);

    // R6: power-fail flag holds while the input stays high
    p_pf_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_q && pwr_fail) |=> pf_q);

    // R6: power-fail flag drops once the input is low
    p_pf_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_fail |=> !pf_q);

    // R7: routed power fail drives only the multifunction pin
    p_route_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_q && enb_q[0] && pf_to_mfo) |-> (!mfo_n));

    // R7: the multifunction pin is used for nothing but power fail
    p_mfo_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !mfo_n |-> (pf_q && pf_to_mfo));

    // R8: summary bit read at address 0 matches the pins
    p_summary_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_MAIN) |-> (bus_rdata[B_SUM] == (!intr_n || !mfo_n)));

    // R9: no enables, no pin activity
    p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_en == '0 && enb_q == '0) |-> (intr_n && mfo_n));
endmodule

bind rtc_irq_ctrl rtc_irq_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .tick      (tick),
    .evt_alarm (evt_alarm),
    .pwr_fail  (pwr_fail),
    .intr_n    (intr_n),
    .mfo_n     (mfo_n),
    .pflag_rd  (pflag_rd),
    .pflag_q   (pflag_q),
    .pf_q      (pf_q),
    .alarm_q   (alarm_q),
    .rate_en   (rate_en),
    .enb_q     (enb_q),
    .pf_to_mfo (pf_to_mfo)
);

// File: tb/tb_rtc_irq_ctrl.sv
// Directed bench for rtc_irq_ctrl: one task per scenario, each self-checking.
module tb_rtc_irq_ctrl;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] bus_addr;
    logic       bus_rd;
    logic       bus_wr;
    logic [7:0] bus_wdata;
    logic [7:0] bus_rdata;
    logic [5:0] tick;
    logic       evt_alarm;
    logic [1:0] evt_aux;
    logic       pwr_fail;
    logic       intr_n;
    logic       mfo_n;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tick(tick), .evt_alarm(evt_alarm), .evt_aux(evt_aux),
        .pwr_fail(pwr_fail), .intr_n(intr_n), .mfo_n(mfo_n)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // One-cycle write; optional events in the same cycle.
    task automatic wr(input logic [2:0] a, input logic [7:0] d,
                      input logic al = 1'b0);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1; evt_alarm = al;
        @(negedge clk);
        bus_wr = 1'b0; evt_alarm = 1'b0;
    endtask

    // One-cycle read; data sampled inside the strobe cycle.
    task automatic rd(input logic [2:0] a, output logic [7:0] d,
                      input logic [5:0] tk = '0);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1; tick = tk;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0; tick = '0;
    endtask

    task automatic pulse(input logic [5:0] tk, input logic al, input logic [1:0] ax);
        @(negedge clk);
        tick = tk; evt_alarm = al; evt_aux = ax;
        @(negedge clk);
        tick = '0; evt_alarm = 1'b0; evt_aux = '0;
    endtask

    task automatic rd_chk(input string req, input logic [2:0] a, input logic [7:0] exp);
        logic [7:0] d;
        rd(a, d);
        check(req, d, exp);
    endtask

    task automatic t_reset();
        check("R1 intr_n", intr_n, 1);
        check("R1 mfo_n", mfo_n, 1);
        rd_chk("R1 main", 3'd0, 8'h00);
        rd_chk("R1 omode", 3'd2, 8'h00);
        rd_chk("R1 pflag", 3'd3, 8'h00);
    endtask

    task automatic t_periodic();
        logic [7:0] d;
        pulse(6'b000010, 1'b0, 2'b00);
        rd_chk("R3 masked main bit", 3'd0, 8'h00);
        rd_chk("R2 flag set without enable", 3'd3, 8'h02);
        rd_chk("R2 cleared by read", 3'd3, 8'h00);
        wr(3'd0, 8'h40);
        wr(3'd3, 8'h04);
        rd_chk("R10 enable A readback", 3'd3, 8'h04);
        wr(3'd0, 8'h00);
        pulse(6'b000100, 1'b0, 2'b00);
        rd_chk("R3 enabled tick sets main bit", 3'd0, 8'h09);
        check("R3 intr_n low", intr_n, 0);
        rd(3'd3, d, 6'b000001);
        check("R2 read returns pre-tick flags", d, 8'h04);
        rd_chk("R2 same-cycle tick survives clear", 3'd3, 8'h01);
        wr(3'd0, 8'h00);
        rd_chk("R5 write zero keeps bit 3", 3'd0, 8'h09);
        wr(3'd0, 8'h08);
        rd_chk("R5 write one clears bit 3", 3'd0, 8'h00);
        check("R5 intr_n released", intr_n, 1);
    endtask

    task automatic t_alarm();
        pulse('0, 1'b1, 2'b00);
        rd_chk("R4 alarm sets without enable", 3'd0, 8'h04);
        check("R4 intr_n stays high", intr_n, 1);
        wr(3'd0, 8'h40);
        wr(3'd4, 8'h02);
        wr(3'd0, 8'h00);
        check("R4 enabled alarm drives intr_n", intr_n, 0);
        rd_chk("R8 summary with alarm", 3'd0, 8'h05);
        wr(3'd0, 8'h04, 1'b1);
        rd_chk("R5 event wins over clear", 3'd0, 8'h05);
        wr(3'd0, 8'h04);
        rd_chk("R5 alarm cleared", 3'd0, 8'h00);
        check("R5 intr_n released", intr_n, 1);
    endtask

    task automatic t_power();
        @(negedge clk); pwr_fail = 1'b1;
        @(negedge clk);
        rd_chk("R6 no set without enable", 3'd0, 8'h00);
        wr(3'd0, 8'h40);
        wr(3'd4, 8'h03);
        wr(3'd0, 8'h00);
        rd_chk("R6 set when enabled", 3'd0, 8'h03);
        check("R7 unrouted uses intr_n", intr_n, 0);
        check("R7 unrouted mfo_n idle", mfo_n, 1);
        wr(3'd0, 8'h02);
        rd_chk("R6 write one does not clear", 3'd0, 8'h03);
        wr(3'd2, 8'h01);
        check("R7 routed intr_n idle", intr_n, 1);
        check("R7 routed mfo_n low", mfo_n, 0);
        rd_chk("R8 summary from mfo_n", 3'd0, 8'h03);
        @(negedge clk); pwr_fail = 1'b0;
        @(negedge clk);
        rd_chk("R6 cleared on restore", 3'd0, 8'h00);
        check("R6 mfo_n released", mfo_n, 1);
        wr(3'd2, 8'h00);
    endtask

    task automatic t_aux();
        pulse('0, 1'b0, 2'b01);
        rd_chk("R11 spare sets bit 4", 3'd0, 8'h10);
        check("R11 intr_n high without enable", intr_n, 1);
        wr(3'd0, 8'h40);
        wr(3'd4, 8'h07);
        wr(3'd0, 8'h00);
        check("R11 enabled spare drives intr_n", intr_n, 0);
        wr(3'd0, 8'h10);
        rd_chk("R11 spare cleared", 3'd0, 8'h00);
    endtask

    task automatic t_noenable();
        wr(3'd0, 8'h40);
        wr(3'd3, 8'h00);
        wr(3'd4, 8'h00);
        wr(3'd0, 8'h00);
        @(negedge clk); pwr_fail = 1'b1;
        pulse(6'b111111, 1'b1, 2'b11);
        check("R9 intr_n quiet", intr_n, 1);
        check("R9 mfo_n quiet", mfo_n, 1);
        rd_chk("R9 flags still pollable", 3'd0, 8'h34);
        @(negedge clk); pwr_fail = 1'b0;
        rd_chk("R9 rate flags pollable", 3'd3, 8'h3F);
        wr(3'd0, 8'h34);
        rd_chk("R5 multi-bit clear", 3'd0, 8'h00);
    endtask

    task automatic t_paging();
        pulse(6'b100000, 1'b0, 2'b00);
        wr(3'd0, 8'h80);
        rd_chk("R10 page 1 hides flags", 3'd3, 8'h00);
        rd_chk("R10 main visible on page 1", 3'd0, 8'h80);
        wr(3'd0, 8'h00);
        rd_chk("R10 page 1 read had no side effect", 3'd3, 8'h20);
        rd_chk("R2 cleared again", 3'd3, 8'h00);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; bus_addr = '0; bus_rd = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
        tick = '0; evt_alarm = 1'b0; evt_aux = '0; pwr_fail = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_periodic();
        t_alarm();
        t_power();
        t_aux();
        t_noenable();
        t_paging();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule